// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block places a bank of 256 byte-wide configuration registers behind two adjacent I/O addresses. Software first writes a register number to the index port. It then reads or writes the selected register through the data port. A read from either port returns the register that the current index selects. The index stays latched until the next write to the index port, so several data accesses can follow one index write.

Each data-port write is filtered by the current index. Most indices are read-only. A small set accepts any byte. Two indices accept a write only when it carries one fixed byte value, so the value they hold cannot change. Decoding of both ports is off after reset. A host configuration write turns it on or off, and while it is off the block ignores the bus.

The bus interface is a synchronous strobe interface. A write completes in the cycle of its one-cycle strobe. Read data is registered and appears one cycle after the read strobe.

Top module: `cfg_idx_port`

## Requirements
- R1: After reset, decoding is disabled, the index is 0x00 and `io_rdata` is 0xFF.
- R2: A host configuration write at offset 0x85 sets the decode enable to bit 1 of `hcfg_wdata`. Host writes at any other offset leave the enable unchanged.
- R3: While decoding is enabled, a write to address 0x3F0 loads the written byte as the index. A read at 0x3F0 or 0x3F1 returns the register that the current index selects.
- R4: `io_rdata` takes the read result on the clock edge that samples `io_rd`, so it is visible the cycle after the strobe. It holds that value until the next read strobe.
- R5: Data writes (address 0x3F1) are ignored at indices 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB and 0xFD–0xFF.
- R6: At index 0xE7 a data write takes effect only when the byte is 0xFE. At index 0xE8 it takes effect only when the byte is 0xBE. Any other byte leaves the register unchanged.
- R7: Indices 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC store any byte written to the data port.
- R8: Reset values are 0x3C at 0xE0, 0x03 at 0xE2, 0xFC at 0xE3, 0xDE at 0xE6, 0xFE at 0xE7 and 0xBE at 0xE8. Every other register is 0x00.
- R9: While decoding is disabled, writes to either port change neither the index nor any register, and every read returns 0xFF.
- R10: Accesses at any address other than 0x3F0 and 0x3F1 have no effect, and reads there return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hcfg_we | input | 1 | Host configuration byte write strobe |
| hcfg_ofs | input | 8 | Host configuration byte offset |
| hcfg_wdata | input | 8 | Host configuration write data |
| io_addr | input | ADDR_W | I/O address of the access |
| io_wr | input | 1 | One-cycle I/O write strobe |
| io_rd | input | 1 | One-cycle I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Registered I/O read data |

## Verification
A wrong index latch shows on the next read. That read returns a neighbouring register's value or reset value, one cycle after the strobe. A wrong write filter appears as a changed or an unchanged byte, but only when a later read visits that index. For that reason the random stimulus mixes index writes, data writes and reads at a high rate, and a directed sweep reads all 256 reset values. A wrong enable state shows on the first read, as 0xFF where data was expected or data where 0xFF was expected.

// File: rtl/cfg_idx_port.sv
module cfg_idx_port #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h03F0,
  parameter logic [7:0] EN_OFS = 8'h85,
  parameter int EN_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hcfg_we,
  input  logic [7:0]        hcfg_ofs,
  input  logic [7:0]        hcfg_wdata,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata
);
  localparam logic [ADDR_W-1:0] DAT_ADDR = IDX_ADDR + 1'b1;
  localparam logic [7:0] EN_MASK = 8'(1 << EN_BIT);
  localparam int HI_N = 32;

  function automatic logic [7:0] rst_val(input int slot);
    case (slot)
      0: rst_val = 8'h3C;
      2: rst_val = 8'h03;
      3: rst_val = 8'hFC;
      6: rst_val = 8'hDE;
      7: rst_val = 8'hFE;
      8: rst_val = 8'hBE;
      default: rst_val = 8'h00;
    endcase
  endfunction

  function automatic logic wr_ok(input logic [4:0] slot, input logic [7:0] d);
    case (slot)
      5'h00, 5'h01, 5'h02, 5'h03, 5'h06,
      5'h0E, 5'h0F, 5'h10, 5'h11, 5'h12,
      5'h14, 5'h16, 5'h18, 5'h1C: wr_ok = 1'b1;
      5'h07: wr_ok = (d == 8'hFE);
      5'h08: wr_ok = (d == 8'hBE);
      default: wr_ok = 1'b0;
    endcase
  endfunction

  logic                 dec_en;
  logic [7:0]           idx_q;
  logic [HI_N-1:0][7:0] regs_q;

  wire hit_idx = dec_en && (io_addr == IDX_ADDR);
  wire hit_dat = dec_en && (io_addr == DAT_ADDR);
  wire idx_wr  = io_wr && hit_idx;
  wire data_wr = io_wr && hit_dat;
  wire rd_hit  = hit_idx || hit_dat;
  wire hi_sel  = (idx_q[7:5] == 3'b111);
  wire [4:0] slot = idx_q[4:0];
  wire [7:0] cur  = hi_sel ? regs_q[slot] : 8'h00;
  wire commit = data_wr && hi_sel && wr_ok(slot, io_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) dec_en <= 1'b0;
    else if (hcfg_we && hcfg_ofs == EN_OFS) dec_en <= |(hcfg_wdata & EN_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= 8'h00;
    else if (idx_wr) idx_q <= io_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) io_rdata <= 8'hFF;
    else if (io_rd) io_rdata <= rd_hit ? cur : 8'hFF;
  end

  for (genvar g = 0; g < HI_N; g++) begin : g_reg
    localparam logic [7:0] RV = rst_val(g);
    always_ff @(posedge clk) begin
      if (!rst_n) regs_q[g] <= RV;
      else if (commit && slot == 5'(g)) regs_q[g] <= io_wdata;
    end
  end
endmodule

// File: rtl/cfg_idx_port_chk.sv
module cfg_idx_port_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         io_rd,
  input logic [7:0]   io_rdata,
  input logic [7:0]   io_wdata,
  input logic         dec_en,
  input logic         idx_wr,
  input logic         data_wr,
  input logic [7:0]   idx_q,
  input logic [255:0] hi_regs
);
  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));
  p_rd_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && !dec_en |=> io_rdata == 8'hFF);
  p_idx_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> idx_q == $past(io_wdata));
  p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |=> $stable(idx_q));
  p_e7_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && idx_q == 8'hE7 |=> hi_regs[63:56] == 8'hFE);
  p_e8_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && idx_q == 8'hE8 |=> hi_regs[71:64] == 8'hBE);
  p_ro_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && idx_q == 8'hE4 |=> $stable(hi_regs[39:32]));
endmodule

bind cfg_idx_port cfg_idx_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_rdata(io_rdata),
  .io_wdata(io_wdata), .dec_en(dec_en), .idx_wr(idx_wr),
  .data_wr(data_wr), .idx_q(idx_q), .hi_regs(regs_q)
);

// File: tb/cfg_idx_port_tb.sv
module cfg_idx_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_IDX = 16'h03F0;
  localparam logic [15:0] A_DAT = 16'h03F1;

  logic clk = 0, rst_n = 0;
  logic hcfg_we = 0;
  logic [7:0] hcfg_ofs = 0, hcfg_wdata = 0;
  logic [15:0] io_addr = 0;
  logic io_wr = 0, io_rd = 0;
  logic [7:0] io_wdata = 0;
  logic [7:0] io_rdata;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] mdl [256];
  logic [7:0] midx;
  bit men;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_idx_port u_dut (.clk(clk), .rst_n(rst_n), .hcfg_we(hcfg_we),
    .hcfg_ofs(hcfg_ofs), .hcfg_wdata(hcfg_wdata), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata));

  function automatic logic allowed(input logic [7:0] i, input logic [7:0] d);
    if (i == 8'hE7) return d == 8'hFE;
    if (i == 8'hE8) return d == 8'hBE;
    if ((i >= 8'hE0 && i <= 8'hE3) || i == 8'hE6) return 1;
    if (i >= 8'hEE && i <= 8'hF2) return 1;
    return i == 8'hF4 || i == 8'hF6 || i == 8'hF8 || i == 8'hFC;
  endfunction

  function automatic logic [7:0] reset_of(input logic [7:0] i);
    case (i)
      8'hE0: return 8'h3C;  8'hE2: return 8'h03;  8'hE3: return 8'hFC;
      8'hE6: return 8'hDE;  8'hE7: return 8'hFE;  8'hE8: return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic host(input logic [7:0] ofs, input logic [7:0] d);
    @(negedge clk); hcfg_we = 1; hcfg_ofs = ofs; hcfg_wdata = d;
    @(negedge clk); hcfg_we = 0;
    if (ofs == 8'h85) men = d[1];
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 0;
    if (men && a == A_IDX) midx = d;
    else if (men && a == A_DAT && allowed(midx, d)) mdl[midx] = d;
  endtask

  task automatic rd(input logic [15:0] a, input string req);
    logic [7:0] exp;
    exp = (men && (a == A_IDX || a == A_DAT)) ? mdl[midx] : 8'hFF;
    @(negedge clk); io_rd = 1; io_addr = a;
    @(negedge clk); io_rd = 0;
    chk(req, io_rdata, exp);
  endtask

  initial begin
    repeat (CLK_PERIOD * 2000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'h0C0FFEE5));
    for (int i = 0; i < 256; i++) mdl[i] = reset_of(8'(i));
    midx = 0; men = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rdata after reset", io_rdata, 8'hFF);
    rd(A_IDX, "R1 disabled after reset");
    wr(A_IDX, 8'hE1); wr(A_DAT, 8'h55);
    rd(A_DAT, "R9 read while disabled");
    host(8'h84, 8'h02);
    rd(A_DAT, "R2 other offset ignored");
    host(8'h85, 8'h02);
    rd(A_IDX, "R1 index zero / R9 write while disabled dropped");
    for (int i = 0; i < 256; i++) begin
      wr(A_IDX, 8'(i));
      rd(A_DAT, "R8 reset value");
    end
    wr(A_IDX, 8'hE1); wr(A_DAT, 8'hA5);
    rd(A_DAT, "R7 free register"); rd(A_IDX, "R3 read at index port");
    held = io_rdata;
    repeat (3) @(negedge clk);
    chk("R4 rdata held", io_rdata, held);
    wr(A_IDX, 8'h10); wr(A_DAT, 8'h77); rd(A_DAT, "R5 low range read-only");
    wr(A_IDX, 8'hE4); wr(A_DAT, 8'h77); rd(A_DAT, "R5 E4 read-only");
    wr(A_IDX, 8'hFF); wr(A_DAT, 8'h77); rd(A_DAT, "R5 FF read-only");
    wr(A_IDX, 8'hE7); wr(A_DAT, 8'h00); rd(A_DAT, "R6 E7 wrong value");
    wr(A_DAT, 8'hFE); rd(A_DAT, "R6 E7 right value");
    wr(A_IDX, 8'hE8); wr(A_DAT, 8'hBF); rd(A_DAT, "R6 E8 wrong value");
    wr(A_IDX, 8'hFC); wr(A_DAT, 8'h99); rd(A_DAT, "R7 FC free");
    rd(16'h03F2, "R10 other address read");
    wr(16'h03F2, 8'h12); wr(16'h02F0, 8'hE0);
    rd(A_DAT, "R10 other address write dropped");
    host(8'h85, 8'hFD);
    rd(A_DAT, "R2 bit1 clear disables");
    wr(A_IDX, 8'hE0); wr(A_DAT, 8'h00);
    host(8'h85, 8'h02);
    rd(A_DAT, "R9 index and data held while disabled");
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [7:0] v;
      op = $urandom_range(0, 99);
      v = 8'($urandom);
      if (op < 30) wr(A_IDX, ($urandom_range(0, 9) < 8) ? (8'hE0 | (v & 8'h1F)) : v);
      else if (op < 60) wr(A_DAT, ($urandom_range(0, 3) == 0) ? (v[0] ? 8'hFE : 8'hBE) : v);
      else if (op < 90) rd(v[0] ? A_DAT : A_IDX, "R3 random read");
      else if (op < 93) rd(16'h03F0 + 16'($urandom_range(2, 15)), "R10 random other address");
      else if (op < 95) wr(16'h03F0 + 16'($urandom_range(2, 15)), v);
      else if (op < 98) host(v[7] ? 8'h85 : v, ($urandom_range(0, 3) != 0) ? 8'h02 : v);
      else rd(A_DAT, "R9 random read");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule